// File: doc/BRIEF.md
# Redundant Safety Alarm Manager

This block gathers alarm lines from on-chip safety mechanisms and hands each one to one of two identical handler units. A routing register picks the handler for each alarm. A reaction register gives each alarm a 2-bit code. The code tells the owning handler to drop the alarm, to raise an interrupt, to pull its own fault pin low, or to pull the pin low and also mark the alarm as critical. Each handler keeps a sticky status bit for every alarm it has accepted. Software clears these bits by writing 1 to them. A handler's fault pin stays asserted until software releases it, and that release has no effect while a fault-level alarm is still pending in the handler.

An always-on supervisor watches both handlers. Each handler emits an alive heartbeat that toggles every `ALIVE_N` cycles while its domain runs. The supervisor flags a handler as dead if it sees no heartbeat edge for `2*ALIVE_N` cycles. The supervisor also receives the critical alarms of both handlers, combined into one line, and a set of common-cause alarm inputs for voltage, temperature and clock. Any of these events drives the shared system fault pin low. That pin stays latched until reset.

Two applications running on one chip can each use one handler and get separate fault reaction paths. The supervisor acts as the second, independent shutdown path for both.

Top module: `sam_alarm_hub`

## Requirements
- R1: After reset, both handler fault pins and the system fault pin read 1 (inactive), both interrupt outputs read 0, and every readable register reads 0. Route 0 means every alarm belongs to handler 0.
- R2: Bit i of the routing register (address 0) selects the owner of alarm i: 0 for handler 0, 1 for handler 1. An alarm changes only the status, interrupt and fault pin of its owner.
- R3: Reaction code 00 (bits 2i+1:2i of address 1) makes alarm i ignored. No status bit is set, no interrupt is raised and no pin changes.
- R4: Reaction code 01 sets the owner's status bit i in the edge that samples the alarm. The owner's `irq_o` bit is high while any pending status bit has code 01. Fault pins are unchanged.
- R5: Reaction code 10 sets status bit i and drives the owner's `fault_no` bit low from the edge that samples the alarm. The other handler's pin and the system pin are unaffected.
- R6: Reaction code 11 acts like code 10. In addition, the pending critical status drives `sys_fault_no` low one edge after the status bit is set.
- R7: Status registers are at address 2 (handler 0) and address 3 (handler 1). They are sticky and cleared by writing 1 to a bit. Writing 0 has no effect. A new alarm in the same cycle as a clear wins.
- R8: Writing 1 to bit h of address 4 releases fault pin h only if handler h has no pending status bit whose code is 10 or 11. Otherwise the write is ignored and the pin stays low.
- R9: While its domain is enabled, each handler's `alive_o` bit toggles every `ALIVE_N` cycles.
- R10: If a handler's domain stalls (`core_en_i` bit low), its alive output stops toggling. The supervisor leaves `sys_fault_no` high for at least `ALIVE_N` cycles after the stall and drives it low once `2*ALIVE_N` cycles pass with no edge.
- R11: Any high bit of `ccf_i` drives `sys_fault_no` low from the next edge.
- R12: Once low, `sys_fault_no` stays low until reset, whatever is written, cleared or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alarm_i | input | NUM_ALARMS | Alarm lines from safety mechanisms, sampled each cycle |
| core_en_i | input | 2 | Per-handler domain run enable; a low bit freezes that handler |
| ccf_i | input | NUM_CCF | Common-cause alarms (voltage, temperature, clock) to the supervisor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 2 | Per-handler interrupt request |
| fault_no | output | 2 | Per-handler fault pin, active low |
| alive_o | output | 2 | Per-handler alive heartbeat |
| sys_fault_no | output | 1 | Shared system fault pin, active low, latched |

## Verification
Constrained random alarm patterns are run against a bench model under random routing, reaction codes, status clears and releases. Sparse multi-alarm vectors show whether routing keeps the two handlers apart. They also show whether each reaction code reaches only its own output: status, interrupt, handler pin or system pin. Directed sequences cover the corner cases. These include a release attempted while a fault alarm is pending versus after it is cleared, an alarm that collides with its own clear, and the one-edge lag between a critical status and the system pin. Stalling one handler tells the window in which the supervisor must stay quiet from the point at which it must fire. A common-cause pulse followed by clears and releases shows that the system pin is latched.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    RX_IGNORE = 2'b00,
    RX_IRQ    = 2'b01,
    RX_FAULT  = 2'b10,
    RX_CRIT   = 2'b11
  } react_e;

  localparam int unsigned N_HND   = 2;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned REG_DW  = 32;

  localparam logic [REG_AW-1:0] A_ROUTE   = 3'd0;
  localparam logic [REG_AW-1:0] A_REACT   = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT0   = 3'd2;
  localparam logic [REG_AW-1:0] A_STAT1   = 3'd3;
  localparam logic [REG_AW-1:0] A_RELEASE = 3'd4;
endpackage

// File: rtl/sam_cfg_regs.sv
module sam_cfg_regs
  import sam_pkg::*;
#(
  parameter int unsigned NA = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [REG_AW-1:0]           wr_addr_i,
  input  logic [REG_DW-1:0]           wr_data_i,
  output logic [NA-1:0]               route_o,
  output logic [2*NA-1:0]             react_o,
  output logic [N_HND-1:0][NA-1:0]    clr_o,
  output logic [N_HND-1:0]            rel_o
);
  logic [NA-1:0]   route_q;
  logic [2*NA-1:0] react_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      react_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_ROUTE) route_q <= wr_data_i[NA-1:0];
      if (wr_addr_i == A_REACT) react_q <= wr_data_i[2*NA-1:0];
    end
  end

  // one-cycle clear strobes per handler status register
  for (genvar h = 0; h < N_HND; h++) begin : g_clr
    localparam logic [REG_AW-1:0] ADDR = A_STAT0 + REG_AW'(h);
    assign clr_o[h] = (wr_en_i && wr_addr_i == ADDR) ? wr_data_i[NA-1:0] : '0;
  end

  assign rel_o   = (wr_en_i && wr_addr_i == A_RELEASE) ? wr_data_i[N_HND-1:0] : '0;
  assign route_o = route_q;
  assign react_o = react_q;
endmodule

// File: rtl/sam_handler.sv
module sam_handler
  import sam_pkg::*;
#(
  parameter int unsigned NA      = 8,
  parameter int unsigned ALIVE_N = 16,
  parameter int unsigned HID     = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [NA-1:0]   alarm_i,
  input  logic [NA-1:0]   route_i,
  input  logic [2*NA-1:0] react_i,
  input  logic [NA-1:0]   clr_i,
  input  logic            rel_i,
  output logic [NA-1:0]   status_o,
  output logic            irq_o,
  output logic            crit_o,
  output logic            fault_no,
  output logic            alive_o
);
  localparam int unsigned CW = (ALIVE_N > 1) ? $clog2(ALIVE_N) : 1;
  localparam logic        OWN_SEL = (HID != 0);

  logic [NA-1:0] mine, act_m, flt_m, irq_m, crit_m;
  logic [NA-1:0] st_q;
  logic          fl_q, hb_q;
  logic [CW-1:0] cnt_q;

  for (genvar i = 0; i < NA; i++) begin : g_dec
    react_e code;
    assign code     = react_e'(react_i[2*i +: 2]);
    assign mine[i]  = (route_i[i] == OWN_SEL);
    assign act_m[i] = (code != RX_IGNORE);
    assign flt_m[i] = (code == RX_FAULT) || (code == RX_CRIT);
    assign irq_m[i] = (code == RX_IRQ);
    assign crit_m[i] = (code == RX_CRIT);
  end

  logic [NA-1:0] hit;
  logic          flt_set, flt_pend;
  assign hit      = alarm_i & mine;
  assign flt_set  = |(hit & flt_m);
  assign flt_pend = |(st_q & flt_m);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      fl_q  <= 1'b0;
      hb_q  <= 1'b0;
      cnt_q <= '0;
    end else if (en_i) begin
      st_q <= (st_q & ~clr_i) | (hit & act_m);
      if (flt_set)                fl_q <= 1'b1;
      else if (rel_i && !flt_pend) fl_q <= 1'b0;
      if (cnt_q == CW'(ALIVE_N - 1)) begin
        cnt_q <= '0;
        hb_q  <= ~hb_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & irq_m);
  assign crit_o   = |(st_q & crit_m);
  assign fault_no = ~fl_q;
  assign alive_o  = hb_q;
endmodule

// File: rtl/sam_supervisor.sv
module sam_supervisor
  import sam_pkg::*;
#(
  parameter int unsigned ALIVE_N = 16,
  parameter int unsigned NC      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_HND-1:0] alive_i,
  input  logic             crit_i,
  input  logic [NC-1:0]    ccf_i,
  output logic             sys_fault_no
);
  localparam int unsigned LIMIT = 2 * ALIVE_N;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [N_HND-1:0] dead;

  for (genvar h = 0; h < N_HND; h++) begin : g_wd
    logic          prev_q, edge_seen;
    logic [CW-1:0] cnt_q;
    assign edge_seen = alive_i[h] ^ prev_q;
    assign dead[h]   = !edge_seen && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        prev_q <= alive_i[h];
        if (edge_seen)                    cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT - 1)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  logic sys_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sys_q <= 1'b0;
    else if (|dead || crit_i || |ccf_i)   sys_q <= 1'b1;
  end

  assign sys_fault_no = ~sys_q;
endmodule

// File: rtl/sam_alarm_hub.sv
module sam_alarm_hub
  import sam_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 8,
  parameter int unsigned ALIVE_N    = 16,
  parameter int unsigned NUM_CCF    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ALARMS-1:0] alarm_i,
  input  logic [1:0]            core_en_i,
  input  logic [NUM_CCF-1:0]    ccf_i,
  input  logic                  wr_en_i,
  input  logic [2:0]            wr_addr_i,
  input  logic [31:0]           wr_data_i,
  input  logic [2:0]            rd_addr_i,
  output logic [31:0]           rd_data_o,
  output logic [1:0]            irq_o,
  output logic [1:0]            fault_no,
  output logic [1:0]            alive_o,
  output logic                  sys_fault_no
);
  localparam int unsigned NA = NUM_ALARMS;

  logic [NA-1:0]             route;
  logic [2*NA-1:0]           react;
  logic [N_HND-1:0][NA-1:0]  clr;
  logic [N_HND-1:0]          rel;
  logic [N_HND-1:0][NA-1:0]  hnd_status;
  logic [N_HND-1:0]          hnd_crit;
  logic                      crit_any;

  sam_cfg_regs #(.NA(NA)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .route_o(route), .react_o(react), .clr_o(clr), .rel_o(rel)
  );

  for (genvar h = 0; h < N_HND; h++) begin : g_hnd
    sam_handler #(.NA(NA), .ALIVE_N(ALIVE_N), .HID(h)) u_hnd (
      .clk_i, .rst_ni,
      .en_i     (core_en_i[h]),
      .alarm_i,
      .route_i  (route),
      .react_i  (react),
      .clr_i    (clr[h]),
      .rel_i    (rel[h]),
      .status_o (hnd_status[h]),
      .irq_o    (irq_o[h]),
      .crit_o   (hnd_crit[h]),
      .fault_no (fault_no[h]),
      .alive_o  (alive_o[h])
    );
  end

  assign crit_any = |hnd_crit;

  sam_supervisor #(.ALIVE_N(ALIVE_N), .NC(NUM_CCF)) u_sup (
    .clk_i, .rst_ni,
    .alive_i (alive_o),
    .crit_i  (crit_any),
    .ccf_i,
    .sys_fault_no
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_ROUTE: rd_data_o[NA-1:0]   = route;
      A_REACT: rd_data_o[2*NA-1:0] = react;
      A_STAT0: rd_data_o[NA-1:0]   = hnd_status[0];
      A_STAT1: rd_data_o[NA-1:0]   = hnd_status[1];
      default: rd_data_o           = '0;
    endcase
  end
endmodule

// File: rtl/sam_alarm_hub_chk.sv
module sam_alarm_hub_chk
  import sam_pkg::*;
#(
  parameter int unsigned NA = 8,
  parameter int unsigned NC = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NC-1:0]            ccf_i,
  input logic                     wr_en_i,
  input logic [2:0]               wr_addr_i,
  input logic [31:0]              wr_data_i,
  input logic [1:0]               fault_no,
  input logic                     sys_fault_no,
  input logic [N_HND-1:0][NA-1:0] hnd_status,
  input logic                     crit_any
);
  a_r12_sys_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_fault_no |=> !sys_fault_no);

  a_r11_ccf_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ccf_i) |=> !sys_fault_no);

  a_r6_crit_escalates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_any |=> !sys_fault_no);

  a_r8_release_h0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_no[0]) |-> $past(wr_en_i && wr_addr_i == A_RELEASE && wr_data_i[0]));

  a_r8_release_h1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_no[1]) |-> $past(wr_en_i && wr_addr_i == A_RELEASE && wr_data_i[1]));

  a_r7_sticky_h0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(hnd_status[0]) & ~hnd_status[0])) |-> $past(wr_en_i && wr_addr_i == A_STAT0));

  a_r7_sticky_h1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(hnd_status[1]) & ~hnd_status[1])) |-> $past(wr_en_i && wr_addr_i == A_STAT1));
endmodule

bind sam_alarm_hub sam_alarm_hub_chk #(.NA(NUM_ALARMS), .NC(NUM_CCF)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ccf_i        (ccf_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .fault_no     (fault_no),
  .sys_fault_no (sys_fault_no),
  .hnd_status   (hnd_status),
  .crit_any     (crit_any)
);

// File: tb/sam_alarm_hub_test.sv
`timescale 1ns/1ps
module sam_alarm_hub_test;
  localparam int unsigned NA = 8;
  localparam int unsigned AN = 16;
  localparam int unsigned NC = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NA-1:0] alarm_i = '0;
  logic [1:0]    core_en_i = 2'b11;
  logic [NC-1:0] ccf_i = '0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic [2:0]    rd_addr_i = '0;
  logic [31:0]   rd_data_o;
  logic [1:0]    irq_o, fault_no, alive_o;
  logic          sys_fault_no;

  always #2 clk = ~clk;

  sam_alarm_hub #(.NUM_ALARMS(NA), .ALIVE_N(AN), .NUM_CCF(NC)) uut (
    .clk_i(clk), .rst_ni, .alarm_i, .core_en_i, .ccf_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .irq_o, .fault_no, .alive_o, .sys_fault_no
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  logic [NA-1:0]   m_route;
  logic [2*NA-1:0] m_react;
  logic [NA-1:0]   m_st [2];
  logic            m_fl [2];
  logic            m_sys;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NA-1:0] code_mask(input logic [2*NA-1:0] r, input int sel);
    logic [NA-1:0] m;
    for (int i = 0; i < NA; i++) begin
      case (sel)
        0: m[i] = |r[2*i +: 2];
        1: m[i] = r[2*i+1];
        2: m[i] = (r[2*i +: 2] == 2'b01);
        default: m[i] = (r[2*i +: 2] == 2'b11);
      endcase
    end
    return m;
  endfunction

  task automatic model_reset();
    m_route = '0; m_react = '0; m_sys = 1'b0;
    for (int h = 0; h < 2; h++) begin m_st[h] = '0; m_fl[h] = 1'b0; end
  endtask

  task automatic model_step(input logic [NA-1:0] al, input logic we, input logic [2:0] wa,
                            input logic [31:0] wd, input logic [NC-1:0] cc);
    logic [NA-1:0] cm, fm, nz, mine, clr, hit;
    logic crit, pend, rel;
    cm = code_mask(m_react, 3);
    fm = code_mask(m_react, 1);
    nz = code_mask(m_react, 0);
    crit = |(m_st[0] & cm) | |(m_st[1] & cm);
    m_sys = m_sys | crit | (|cc);
    for (int h = 0; h < 2; h++) begin
      if (core_en_i[h]) begin
        mine = (h == 0) ? ~m_route : m_route;
        clr  = (we && wa == 3'(2 + h)) ? wd[NA-1:0] : '0;
        hit  = al & mine;
        pend = |(m_st[h] & fm);
        rel  = we && wa == 3'd4 && wd[h];
        if (|(hit & fm)) m_fl[h] = 1'b1;
        else if (rel && !pend) m_fl[h] = 1'b0;
        m_st[h] = (m_st[h] & ~clr) | (hit & nz);
      end
    end
    if (we && wa == 3'd0) m_route = wd[NA-1:0];
    if (we && wa == 3'd1) m_react = wd[2*NA-1:0];
  endtask

  // drive at negedge, model at posedge, return at next negedge
  task automatic cyc(input logic [NA-1:0] al, input logic we, input logic [2:0] wa,
                     input logic [31:0] wd, input logic [NC-1:0] cc);
    alarm_i = al; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd; ccf_i = cc;
    @(posedge clk);
    model_step(al, we, wa, wd, cc);
    @(negedge clk);
    alarm_i = '0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; ccf_i = '0;
  endtask

  task automatic idle();
    cyc('0, 1'b0, 3'd0, 32'd0, '0);
  endtask

  task automatic compare_all(input string req);
    logic [NA-1:0] im0, im1;
    im0 = code_mask(m_react, 2);
    im1 = im0;
    chk({req, " fault pins"}, {30'd0, fault_no}, {30'd0, ~m_fl[1], ~m_fl[0]});
    chk({req, " irq"}, {30'd0, irq_o}, {30'd0, |(m_st[1] & im1), |(m_st[0] & im0)});
    chk({req, " sys pin"}, {31'd0, sys_fault_no}, {31'd0, ~m_sys});
    rd_addr_i = 3'd2; #0.4;
    chk({req, " status0"}, rd_data_o, {24'd0, m_st[0]});
    rd_addr_i = 3'd3; #0.4;
    chk({req, " status1"}, rd_data_o, {24'd0, m_st[1]});
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; core_en_i = 2'b11;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin : main
    int seen, gap;
    logic prev;
    void'($urandom(32'h5A17_C0DE));
    do_reset();

    // R1 reset state
    chk("R1 fault pins", {30'd0, fault_no}, 32'd3);
    chk("R1 sys pin", {31'd0, sys_fault_no}, 32'd1);
    chk("R1 irq", {30'd0, irq_o}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd_addr_i = 3'(a); #0.4;
      chk("R1 register", rd_data_o, 32'd0);
    end

    // R3 all codes 00: everything ignored
    cyc(8'hFF, 1'b0, 3'd0, 32'd0, '0);  compare_all("R3");
    chk("R3 no pin", {30'd0, fault_no}, 32'd3);

    // R4 alarm1 code 01
    cyc('0, 1'b1, 3'd1, 32'h0004, '0);
    cyc(8'h02, 1'b0, 3'd0, 32'd0, '0);  compare_all("R4");
    chk("R4 irq0 only", {30'd0, irq_o}, 32'd1);
    chk("R4 pins unchanged", {30'd0, fault_no}, 32'd3);

    // R2/R5 alarm2 routed to handler1, code 10
    cyc('0, 1'b1, 3'd0, 32'h04, '0);
    cyc('0, 1'b1, 3'd1, 32'h0024, '0);
    cyc(8'h04, 1'b0, 3'd0, 32'd0, '0);  compare_all("R5");
    chk("R2 only handler1 pin", {30'd0, fault_no}, 32'd1);
    chk("R5 sys untouched", {31'd0, sys_fault_no}, 32'd1);

    // R8 release while pending is ignored, then after clear it works
    cyc('0, 1'b1, 3'd4, 32'h2, '0);     compare_all("R8");
    chk("R8 pending blocks release", {30'd0, fault_no}, 32'd1);
    cyc('0, 1'b1, 3'd3, 32'h4, '0);     compare_all("R7");
    cyc('0, 1'b1, 3'd4, 32'h2, '0);     compare_all("R8");
    chk("R8 released", {30'd0, fault_no}, 32'd3);

    // R7 set wins over clear; zero write no effect
    cyc(8'h02, 1'b1, 3'd2, 32'h02, '0); compare_all("R7");
    rd_addr_i = 3'd2; #0.4;
    chk("R7 set wins", rd_data_o & 32'h2, 32'h2);
    cyc('0, 1'b1, 3'd2, 32'h0, '0);     compare_all("R7");

    // R6 alarm0 code 11: handler pin now, sys one edge later
    cyc('0, 1'b1, 3'd1, 32'h0027, '0);
    cyc(8'h01, 1'b0, 3'd0, 32'd0, '0);  compare_all("R6");
    chk("R6 sys not yet", {31'd0, sys_fault_no}, 32'd1);
    idle();                              compare_all("R6");
    chk("R6 sys low", {31'd0, sys_fault_no}, 32'd0);

    // R12 latched through clears and releases
    cyc('0, 1'b1, 3'd2, 32'hFF, '0);
    cyc('0, 1'b1, 3'd3, 32'hFF, '0);
    cyc('0, 1'b1, 3'd4, 32'h3, '0);
    repeat (5) idle();
    compare_all("R12");
    chk("R12 sys latched", {31'd0, sys_fault_no}, 32'd0);

    // random phase, R2 R4 R5 R7 R8 under mixed patterns
    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic [NA-1:0] al;
      logic we;
      logic [2:0] wa;
      logic [31:0] wd;
      al = NA'($urandom & $urandom & $urandom);
      we = ($urandom_range(0, 3) == 0);
      wa = 3'($urandom_range(0, 4));
      wd = $urandom;
      if (n < 40) begin we = 1'b1; wa = 3'(n % 2); end
      cyc(al, we, wa, wd, '0);
      compare_all("R2/R5 random");
    end

    // R9 heartbeat period
    do_reset();
    prev = alive_o[0]; seen = 0;
    while (alive_o[0] == prev && seen < 3*AN) begin @(negedge clk); seen++; end
    prev = alive_o[0]; gap = 0;
    while (alive_o[0] == prev && gap < 3*AN) begin @(negedge clk); gap++; end
    chk("R9 alive period", gap, AN);

    // R10 stalled handler
    do_reset();
    core_en_i = 2'b01;
    repeat (AN) @(negedge clk);
    chk("R10 quiet window", {31'd0, sys_fault_no}, 32'd1);
    repeat (2*AN + 4) @(negedge clk);
    chk("R10 stall detected", {31'd0, sys_fault_no}, 32'd0);
    core_en_i = 2'b11;

    // R11 common-cause input
    do_reset();
    chk("R11 before", {31'd0, sys_fault_no}, 32'd1);
    cyc('0, 1'b0, 3'd0, 32'd0, 3'b100);
    compare_all("R11");
    chk("R11 sys low", {31'd0, sys_fault_no}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule